// File: doc/BRIEF.md
# Mode-Aware AES Counter Block Generator

This block holds the 128-bit initialization vector / counter value of an AES engine. Software reaches it as four 32-bit words through a simple register port. Each time the cipher datapath takes a new data block, the block presents a 128-bit counter block. The first block after a load or an operation start uses the stored value unchanged. Every later block first advances the value, and the step depends on the selected cipher mode. The chained mode and the MAC mode never advance it.

The value is a big-endian byte string. Byte 0 occupies bits [7:0] and byte 15 occupies bits [127:120]. Byte 15 is the least significant counter byte, and carries move toward byte 0. The counter mode advances all sixteen bytes. The Galois/counter mode advances only the top word. The CCM mode advances the last L+1 bytes, with L taken from the control register. At the end of an operation the core writes back a full 128-bit result (a chained IV or a MAC tag), so a following operation can continue from it.

Top module: `ctr_block_gen`

## Requirements
- R1: After reset all four words read zero, and the first block submitted then presents zero.
- R2: Word address 0, 1, 2 and 3 reads and writes bits [31:0], [63:32], [95:64] and [127:96] of the register.
- R3: After any accepted word write or operation start, the next block submission presents the stored value unchanged and leaves the register unchanged.
- R4: In counter mode (mode code 1), each later submission adds one to the whole 128-bit value. Byte 15 (bits [127:120]) is least significant, carries run toward byte 0, and the value wraps to zero after all ones.
- R5: In Galois/counter mode (mode code 2), only bytes 12..15 (bits [127:96]) advance, with word 3 = 0x01000000 meaning count 1. The value wraps modulo 2^32 and bits [95:0] never change.
- R6: In CCM mode (mode code 3), only the last L+1 bytes advance, where L is ccm_l_i. The field wraps modulo 2^(8(L+1)), and the flags and nonce bytes never change.
- R7: In CBC (mode code 0) and CBC-MAC (mode code 4), block submissions present the stored value and never change it.
- R8: A write-back strobe loads all 128 bits from wb_data_i. A write-back takes priority over a bus word write in the same cycle, and a bus write takes priority over a block advance.
- R9: An operation start re-arms first use without changing the stored value.
- R10: Mode codes 5 to 7 behave as non-advancing modes.
- R11: After each submission the register holds the counter block just presented, readable through the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Word write strobe |
| reg_addr_i | input | 2 | Word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed word (combinational) |
| mode_i | input | 3 | Cipher mode code |
| ccm_l_i | input | 3 | CCM length field L from the control register |
| op_start_i | input | 1 | Operation start pulse |
| blk_req_i | input | 1 | New data block submitted this cycle |
| blk_ctr_o | output | 128 | Counter block for the submitted data block |
| wb_valid_i | input | 1 | Core result write-back strobe |
| wb_data_i | input | 128 | Core result value (IV or tag) |

## Verification
On every cycle, the assertions check that a first-use submission leaves the register untouched and that bytes outside the active counter field never change. They also check that the Galois mode keeps the lower 96 bits, that the chained and MAC modes hold the value, and that a write-back wins over a bus write. An operation start is checked to re-arm first use. The actual counter arithmetic is shown only by the bench's scenarios. These cover carries across byte boundaries, wrap at each field width, the byte order of the GCM start value, CCM with small and large L, and chaining from written-back results.

// File: rtl/aes_cbg_pkg.sv
package aes_cbg_pkg;
  typedef enum logic [2:0] {
    MODE_CBC     = 3'd0,
    MODE_CTR     = 3'd1,
    MODE_GCM     = 3'd2,
    MODE_CCM     = 3'd3,
    MODE_CBC_MAC = 3'd4
  } cbg_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/aes_cbg_field_mask.sv
module aes_cbg_field_mask
  import aes_cbg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned GCM_BYTES = 4
) (
  input  logic [2:0]           mode_i,
  input  logic [2:0]           ccm_l_i,
  output logic [NUM_BYTES-1:0] mask_o
);
  localparam int GCM_LO = int'(NUM_BYTES) - int'(GCM_BYTES);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_comb begin
      unique case (mode_i)
        MODE_CTR: mask_o[b] = 1'b1;
        MODE_GCM: mask_o[b] = (b >= GCM_LO);
        // CCM counter field: last L+1 bytes
        MODE_CCM: mask_o[b] = (b >= int'(NUM_BYTES) - 1 - int'(ccm_l_i));
        default:  mask_o[b] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/aes_cbg_incr.sv
module aes_cbg_incr
  import aes_cbg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 16
) (
  input  logic [BYTE_W*NUM_BYTES-1:0] val_i,
  input  logic [NUM_BYTES-1:0]        mask_i,
  output logic [BYTE_W*NUM_BYTES-1:0] val_o
);
  // sat: byte is inside field and at all ones (passes a carry)
  logic [NUM_BYTES-1:0] sat;
  logic [NUM_BYTES-1:0] cin;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign sat[b] = mask_i[b] & (&val_i[BYTE_W*b +: BYTE_W]);
    if (b == NUM_BYTES - 1) begin : g_lsb
      assign cin[b] = 1'b1;
    end else begin : g_upper
      assign cin[b] = &sat[NUM_BYTES-1:b+1];
    end
    assign val_o[BYTE_W*b +: BYTE_W] = mask_i[b]
        ? val_i[BYTE_W*b +: BYTE_W] + {{(BYTE_W-1){1'b0}}, cin[b]}
        : val_i[BYTE_W*b +: BYTE_W];
  end
endmodule

// File: rtl/ctr_block_gen.sv
module ctr_block_gen
  import aes_cbg_pkg::*;
#(
  parameter int unsigned BLK_W     = 128,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned GCM_BYTES = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_we_i,
  input  logic [$clog2(BLK_W/WORD_W)-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]                 reg_wdata_i,
  output logic [WORD_W-1:0]                 reg_rdata_o,
  input  logic [2:0]                        mode_i,
  input  logic [2:0]                        ccm_l_i,
  input  logic                              op_start_i,
  input  logic                              blk_req_i,
  output logic [BLK_W-1:0]                  blk_ctr_o,
  input  logic                              wb_valid_i,
  input  logic [BLK_W-1:0]                  wb_data_i
);
  localparam int unsigned NUM_WORDS = BLK_W / WORD_W;
  localparam int unsigned NUM_BYTES = BLK_W / BYTE_W;
  localparam int unsigned GCM_W     = GCM_BYTES * BYTE_W;

  logic [NUM_WORDS-1:0][WORD_W-1:0] iv_q;
  logic [BLK_W-1:0]                 iv_flat;
  logic [BLK_W-1:0]                 iv_inc;
  logic [BLK_W-1:0]                 bit_mask;
  logic [NUM_BYTES-1:0]             byte_mask;
  logic                             first_q;
  logic                             bus_wr;
  logic                             advance;

  assign iv_flat     = iv_q;
  assign reg_rdata_o = iv_q[reg_addr_i];
  assign bus_wr      = reg_we_i & ~wb_valid_i;
  assign advance     = blk_req_i & ~wb_valid_i & ~reg_we_i;

  aes_cbg_field_mask #(
    .NUM_BYTES (NUM_BYTES),
    .GCM_BYTES (GCM_BYTES)
  ) i_mask (
    .mode_i  (mode_i),
    .ccm_l_i (ccm_l_i),
    .mask_o  (byte_mask)
  );

  aes_cbg_incr #(
    .NUM_BYTES (NUM_BYTES)
  ) i_incr (
    .val_i  (iv_flat),
    .mask_i (byte_mask),
    .val_o  (iv_inc)
  );

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_bmask
    assign bit_mask[BYTE_W*b +: BYTE_W] = {BYTE_W{byte_mask[b]}};
  end

  assign blk_ctr_o = first_q ? iv_flat : iv_inc;

  // priority: core write-back > bus word write > block advance
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        iv_q[w] <= '0;
      end else if (wb_valid_i) begin
        iv_q[w] <= wb_data_i[WORD_W*w +: WORD_W];
      end else if (reg_we_i) begin
        if (reg_addr_i == w) iv_q[w] <= reg_wdata_i;
      end else if (blk_req_i) begin
        iv_q[w] <= blk_ctr_o[WORD_W*w +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      first_q <= 1'b1;
    else if (op_start_i || bus_wr)    first_q <= 1'b1;
    else if (blk_req_i)               first_q <= 1'b0;
  end

  assert_first_use_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance && first_q |=> iv_flat == $past(iv_flat));

  assert_outside_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> ((iv_flat ^ $past(iv_flat)) & ~$past(bit_mask)) == '0);

  assert_gcm_low_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance && mode_i == MODE_GCM |=>
      iv_flat[BLK_W-GCM_W-1:0] == $past(iv_flat[BLK_W-GCM_W-1:0]));

  assert_cbc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance && (mode_i == MODE_CBC || mode_i == MODE_CBC_MAC) |=> $stable(iv_flat));

  assert_wb_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> iv_flat == $past(wb_data_i));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i && !wb_valid_i && !reg_we_i && !blk_req_i |=> first_q && $stable(iv_flat));
endmodule

// File: tb/test_ctr_block_gen.sv
module test_ctr_block_gen;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [2:0]   mode = 3'd0;
  logic [2:0]   ccm_l = 3'd0;
  logic         op_start = 1'b0;
  logic         blk_req = 1'b0;
  logic [127:0] blk_ctr;
  logic         wb_valid = 1'b0;
  logic [127:0] wb_data = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_block_gen i_ctr_block_gen (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (reg_we), .reg_addr_i (reg_addr),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata), .mode_i (mode),
    .ccm_l_i (ccm_l), .op_start_i (op_start), .blk_req_i (blk_req),
    .blk_ctr_o (blk_ctr), .wb_valid_i (wb_valid), .wb_data_i (wb_data)
  );

  function automatic logic [127:0] swap(logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*(15-i) +: 8] = v[8*i +: 8];
    return r;
  endfunction

  // expected advance: field of nbytes at the end of a big-endian byte string
  function automatic logic [127:0] model_inc(logic [127:0] v, int nbytes);
    logic [127:0] be, m;
    be = swap(v);
    m  = (nbytes >= 16) ? '1 : ((128'd1 << (8*nbytes)) - 128'd1);
    be = (be & ~m) | ((be + 128'd1) & m);
    return swap(be);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(logic [127:0] v);
    for (int w = 0; w < 4; w++) wr(w, v[32*w +: 32]);
  endtask

  task automatic rd_all(output logic [127:0] v);
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      reg_addr = 2'(w);
      #1 v[32*w +: 32] = reg_rdata;
    end
  endtask

  task automatic submit(output logic [127:0] o);
    @(negedge clk);
    blk_req = 1'b1;
    #1 o = blk_ctr;
    @(negedge clk);
    blk_req = 1'b0;
  endtask

  task automatic start_op();
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic test_reset();
    logic [127:0] r, o;
    rd_all(r);
    chk("R1 reset words", r, '0);
    mode = 3'd1;
    submit(o);
    chk("R1 first block after reset", o, '0);
  endtask

  task automatic test_word_map();
    logic [127:0] o;
    mode = 3'd0;
    wr(0, 32'h11112222); wr(1, 32'h33334444); wr(2, 32'h13572468); wr(3, 32'h9abcdef0);
    submit(o);
    chk("R2 word map", o, {32'h9abcdef0, 32'h13572468, 32'h33334444, 32'h11112222});
  endtask

  task automatic test_ctr();
    logic [127:0] v, o1, o2, o3, r;
    v = {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12060504, 32'h03020100};
    mode = 3'd1;
    load(v);
    submit(o1); chk("R3 ctr first use", o1, v);
    submit(o2); chk("R4 ctr carry across bytes", o2, model_inc(v, 16));
    chk("R4 ctr carry value", o2, {64'h0, 32'h13060504, 32'h03020100});
    submit(o3); chk("R4 ctr third block", o3, model_inc(model_inc(v, 16), 16));
    rd_all(r);  chk("R11 register holds last block", r, o3);
    load('1);
    submit(o1);
    submit(o2); chk("R4 ctr wrap", o2, '0);
  endtask

  task automatic test_gcm();
    logic [127:0] v, o;
    v = {32'h01000000, 32'hCAFEBABE, 32'h01234567, 32'h89ABCDEF};
    mode = 3'd2;
    load(v);
    submit(o); chk("R5 gcm first", o, v);
    submit(o); chk("R5 gcm count 2", o, {32'h02000000, v[95:0]});
    v = {32'hFFFFFFFF, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'hFFFFFFFF};
    load(v);
    submit(o);
    submit(o); chk("R5 gcm wrap keeps low bits", o, {32'h0, v[95:0]});
  endtask

  task automatic test_ccm();
    logic [127:0] v, o;
    mode = 3'd3; ccm_l = 3'd1;
    v = {32'hFFFF5678, 32'h0B0A0908, 32'h07060504, 32'h03020101};
    load(v);
    submit(o); chk("R6 ccm first", o, v);
    submit(o); chk("R6 ccm L=1 wrap no spill", o, {32'h00005678, v[95:0]});
    ccm_l = 3'd7;
    v = {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0E0D0C0B, 32'h0A090807};
    load(v);
    submit(o);
    submit(o); chk("R6 ccm L=7", o, model_inc(v, 8));
    chk("R6 ccm L=7 nonce kept", o, {64'h0, v[63:0]});
  endtask

  task automatic test_cbc();
    logic [127:0] v, o, r;
    mode = 3'd0;
    v = {32'hDEADBEEF, 32'h00C0FFEE, 32'h55555555, 32'hFFFFFFFF};
    load(v);
    submit(o); submit(o); submit(o);
    chk("R7 cbc no advance", o, v);
    mode = 3'd4;
    load('0);
    submit(o); submit(o);
    chk("R7 cbcmac no advance", o, '0);
    mode = 3'd5;
    load(v);
    submit(o); submit(o);
    chk("R10 unused mode no advance", o, v);
    rd_all(r); chk("R10 register kept", r, v);
  endtask

  task automatic test_wb();
    logic [127:0] r, o, t;
    t = {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0};
    @(negedge clk);
    wb_valid = 1'b1; wb_data = t;
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hDEADDEAD;
    @(negedge clk);
    wb_valid = 1'b0; reg_we = 1'b0;
    rd_all(r); chk("R8 writeback wins over bus write", r, t);
    mode = 3'd1;
    start_op();
    submit(o); chk("R8 chain from writeback", o, t);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
    blk_req = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; blk_req = 1'b0;
    rd_all(r); chk("R8 bus write over advance", r, {t[127:64], 32'h0, t[31:0]});
  endtask

  task automatic test_restart();
    logic [127:0] v, o, r;
    mode = 3'd1;
    v = {32'h10000000, 32'h0, 32'h0, 32'h1};
    load(v);
    submit(o); submit(o);
    start_op();
    rd_all(r); chk("R9 start keeps value", r, model_inc(v, 16));
    submit(o); chk("R9 first use after start", o, model_inc(v, 16));
    submit(o); chk("R9 advance after start", o, model_inc(model_inc(v, 16), 16));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_word_map();
    test_ctr();
    test_gcm();
    test_ccm();
    test_cbc();
    test_wb();
    test_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule